// File: doc/BRIEF.md
# Oversampled UART Receive Recovery

This block turns an asynchronous serial line into framed characters. It samples the RX pin once per oversampling tick: 16 ticks per bit in normal mode, 8 in double-speed mode. Baud-rate division happens outside the block and delivers those ticks. A falling edge on the idle line arms start detection. The start bit must then survive a 2-of-3 vote taken at fixed sample positions, so short noise spikes are dropped.

Every later bit is decided by a 2-of-3 vote on the three centre samples of that bit. The block assembles 5 to 9 data bits, sent least-significant first, plus an optional parity bit. It checks only the first stop bit. It reports the character with a one-cycle strobe, a parity-error flag and a framing-error flag. It re-arms for the next start edge straight after the last stop-bit voting sample. The surrounding logic owns any receive buffer.

Top module: `uart_rx_recover`

## Requirements
- R1: After rst_ni is released, frame_valid_o, data_o, bit9_o, parity_err_o and frame_err_o are all 0.
- R2: A frame begins when two consecutive ticked samples read high then low. The low sample is sample 1. After reset, or after enable, the line must first be seen high before a low sample counts as an edge.
- R3: The start bit is voted on samples 8, 9 and 10 in normal mode, and on samples 4, 5 and 6 in double-speed mode. If two or three of them are high, the frame is dropped with no strobe, and the block waits for a new falling edge.
- R4: Every data, parity and stop bit takes the majority value of the same three centre samples (first centre sample = half the samples per bit). A single disagreeing sample does not change the result.
- R5: data_bits_i selects 5 to 9 data bits. Values below 5 are treated as 5, and values above 9 as 9. Bits arrive least-significant first. data_o holds the first min(n,8) bits with the unused upper bits 0. bit9_o is the ninth data bit when 9 are configured, and 0 otherwise.
- R6: parity_mode_i is 00 for no parity, 01 for even and 10 for odd; 11 is treated as no parity. parity_err_o is set when the XOR of the voted data bits and the voted parity bit differs from 0 (even) or from 1 (odd). It is always 0 when parity is off.
- R7: Only the first stop bit is voted. If its voted value is 0, frame_err_o is 1.
- R8: frame_valid_o pulses for exactly one clock, on the clock after the tick that carries the last stop-bit voting sample. data_o, bit9_o and both error flags update with it and hold until the next strobe.
- R9: The block is idle again straight after that last voting sample. A start edge on the very next tick is accepted.
- R10: While en_i is low, the block returns to idle at once and emits no strobe for a partial frame.
- R11: dbl_speed_i = 1 selects 8 samples per bit. The same voting positions apply, scaled to 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Oversampling strobe, one clock wide |
| dbl_speed_i | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| data_bits_i | input | 4 | Data bits per frame (5..9) |
| parity_mode_i | input | 2 | 00 none, 01 even, 10 odd |
| rx_i | input | 1 | Serial receive line |
| frame_valid_o | output | 1 | One-cycle frame strobe |
| data_o | output | 8 | Received data bits 0..7 |
| bit9_o | output | 1 | Ninth data bit |
| parity_err_o | output | 1 | Parity mismatch on the reported frame |
| frame_err_o | output | 1 | First stop bit voted low |

## Verification
The RX line passes through a two-flop synchroniser, so the bench changes a line level three clocks before the tick that is meant to sample it. The level the block sees on each tick is therefore exactly the one the bench intended. The strobe and the frame fields are due one clock after the tick carrying the last stop-bit voting sample, and the bench checks them on the falling edge that follows that tick. One clock later it confirms that the strobe has dropped. Dropped spikes, disabled partial frames and edges seen without a preceding high are checked by counting strobes over the whole stimulus window. A following frame then proves that the block has returned to idle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned MIN_DATA_BITS = 5;
  localparam int unsigned MAX_DATA_BITS = 9;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RESET_VAL;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RESET_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter  int unsigned OVS = 16,
  localparam int unsigned CW  = $clog2(OVS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dbl_i,
  input  logic run_i,
  input  logic load_i,
  input  logic rx_i,
  output logic vote_valid_o,
  output logic vote_o
);
  localparam int unsigned OVS_DBL = OVS / 2;

  logic [CW-1:0] span, v_first, cnt_q, cnt_nxt;
  logic          s0_q, s1_q;

  always_comb begin
    span    = dbl_i ? CW'(OVS_DBL) : CW'(OVS);
    v_first = span >> 1;
    cnt_nxt = (cnt_q >= span) ? CW'(1) : cnt_q + CW'(1);
  end

  // cnt_q holds the index of the sample processed last; load marks sample 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      s0_q  <= 1'b1;
      s1_q  <= 1'b1;
    end else if (load_i) begin
      cnt_q <= CW'(1);
    end else if (run_i && tick_i) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == v_first)          s0_q <= rx_i;
      if (cnt_nxt == v_first + CW'(1)) s1_q <= rx_i;
    end
  end

  assign vote_valid_o = run_i && tick_i && (cnt_nxt == v_first + CW'(2));
  assign vote_o       = maj3(s0_q, s1_q, rx_i);

  assert_cnt_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0) && (cnt_q <= CW'(OVS)));

  assert_single_vote_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vote_valid_o |=> !vote_valid_o);
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       dbl_speed_i,
  input  logic [3:0] data_bits_i,
  input  logic [1:0] parity_mode_i,
  input  logic       rx_i,
  output logic       frame_valid_o,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       parity_err_o,
  output logic       frame_err_o
);
  localparam int unsigned IDX_W = $clog2(MAX_DATA_BITS + 3);

  rx_state_e                state_q;
  logic                     rx_s, prev_q;
  logic [IDX_W-1:0]         idx_q, nbits, stop_idx;
  logic [MAX_DATA_BITS-1:0] data_q;
  logic                     acc_q, par_q;
  logic                     par_en, par_odd, start_edge, run, vote_valid, vote;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  always_comb begin
    if (data_bits_i < 4'(MIN_DATA_BITS))      nbits = IDX_W'(MIN_DATA_BITS);
    else if (data_bits_i > 4'(MAX_DATA_BITS)) nbits = IDX_W'(MAX_DATA_BITS);
    else                                      nbits = IDX_W'(data_bits_i);
    par_en     = (parity_mode_i == PAR_EVEN) || (parity_mode_i == PAR_ODD);
    par_odd    = (parity_mode_i == PAR_ODD);
    stop_idx   = nbits + IDX_W'(par_en) + IDX_W'(1);
    start_edge = en_i && (state_q == ST_IDLE) && tick_i && prev_q && !rx_s;
    run        = en_i && (state_q == ST_ACTIVE);
  end

  uart_rx_sampler #(.OVS(OVS)) i_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .dbl_i       (dbl_speed_i),
    .run_i       (run),
    .load_i      (start_edge),
    .rx_i        (rx_s),
    .vote_valid_o(vote_valid),
    .vote_o      (vote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      prev_q        <= 1'b0;
      idx_q         <= '0;
      data_q        <= '0;
      acc_q         <= 1'b0;
      par_q         <= 1'b0;
      frame_valid_o <= 1'b0;
      data_o        <= '0;
      bit9_o        <= 1'b0;
      parity_err_o  <= 1'b0;
      frame_err_o   <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        prev_q  <= 1'b0; // a high must be seen again before an edge counts
      end else if (state_q == ST_IDLE) begin
        if (tick_i) prev_q <= rx_s;
        if (start_edge) begin
          state_q <= ST_ACTIVE;
          idx_q   <= '0;
          data_q  <= '0;
          acc_q   <= 1'b0;
          par_q   <= 1'b0;
        end
      end else if (vote_valid) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == '0) begin
          if (vote) begin // spike: start rejected
            state_q <= ST_IDLE;
            prev_q  <= rx_s;
          end
        end else if (idx_q == stop_idx) begin
          state_q       <= ST_IDLE;
          prev_q        <= rx_s;
          frame_valid_o <= 1'b1;
          data_o        <= data_q[7:0];
          bit9_o        <= data_q[MAX_DATA_BITS-1];
          parity_err_o  <= par_en && (acc_q ^ par_q ^ par_odd);
          frame_err_o   <= !vote;
        end else if (idx_q <= nbits) begin
          for (int i = 0; i < int'(MAX_DATA_BITS); i++) begin
            if (idx_q == IDX_W'(i + 1)) data_q[i] <= vote;
          end
          acc_q <= acc_q ^ vote;
        end else begin
          par_q <= vote;
        end
      end
    end
  end

  assert_off_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);

  assert_off_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !frame_valid_o);

  assert_strobe_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  assert_strobe_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(state_q == ST_ACTIVE) && $past(tick_i));

  assert_no_parity_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && $past(!par_en) |-> !parity_err_o);

  assert_idx_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACTIVE |-> idx_q <= IDX_W'(MAX_DATA_BITS + 2));
endmodule

// File: tb/test_uart_rx_recover.sv
module test_uart_rx_recover;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic       dbl;
    logic [3:0] nbits;
    logic [1:0] pmode;
    logic [8:0] data;
    logic       bad_par;
    logic       bad_stop;
    logic       noise;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd8, 2'b00, 9'h0A5, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd8, 2'b01, 9'h03C, 1'b0, 1'b0, 1'b1},
    '{1'b0, 4'd7, 2'b10, 9'h055, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'd8, 2'b00, 9'h0C3, 1'b0, 1'b0, 1'b1},
    '{1'b1, 4'd9, 2'b01, 9'h1F0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 4'd5, 2'b10, 9'h01F, 1'b0, 1'b1, 1'b0},
    '{1'b0, 4'd9, 2'b00, 9'h0AA, 1'b0, 1'b1, 1'b1},
    '{1'b1, 4'd6, 2'b10, 9'h02D, 1'b1, 1'b0, 1'b1},
    '{1'b0, 4'd5, 2'b01, 9'h3FF, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       tick = 1'b0;
  logic       dbl = 1'b0;
  logic [3:0] nbits = 4'd8;
  logic [1:0] pmode = 2'b00;
  logic       rx = 1'b1;
  logic       fv, b9, perr, ferr;
  logic [7:0] dout;

  int total = 0;
  int bad = 0;
  int strobes = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_recover i_uart_rx_recover (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .tick_i       (tick),
    .dbl_speed_i  (dbl),
    .data_bits_i  (nbits),
    .parity_mode_i(pmode),
    .rx_i         (rx),
    .frame_valid_o(fv),
    .data_o       (dout),
    .bit9_o       (b9),
    .parity_err_o (perr),
    .frame_err_o  (ferr)
  );

  always @(posedge clk) if (fv) strobes <= strobes + 1;

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // one ticked sample; level settles through the synchroniser before the tick
  task automatic put_sample(input logic v);
    @(negedge clk);
    rx = v;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int span, input logic noise);
    for (int s = 1; s <= span; s++) put_sample((noise && s == span / 2) ? ~v : v);
  endtask

  task automatic run_frame(input vec_t vc, input int idle, input logic full_stop, input string req);
    int         span;
    logic [8:0] mask;
    logic       p, sv;
    int         exp_data;
    span = vc.dbl ? 8 : 16;
    mask = 9'((1 << vc.nbits) - 1);
    p    = ^(vc.data & mask);
    if (vc.pmode == 2'b10) p = ~p;
    if (vc.bad_par) p = ~p;
    sv   = ~vc.bad_stop;
    exp_data = int'(vc.data[7:0] & mask[7:0]);
    @(negedge clk);
    dbl = vc.dbl;
    nbits = vc.nbits;
    pmode = vc.pmode;
    for (int i = 0; i < idle; i++) put_sample(1'b1);
    send_bit(1'b0, span, vc.noise);
    for (int i = 0; i < int'(vc.nbits); i++) send_bit(vc.data[i], span, vc.noise);
    if (vc.pmode == 2'b01 || vc.pmode == 2'b10) send_bit(p, span, vc.noise);
    for (int s = 1; s <= span / 2 + 2; s++) put_sample((vc.noise && s == span / 2) ? ~sv : sv);
    check(req, "strobe after last stop vote (R8)", int'(fv), 1);
    check(req, "data (R5)", int'(dout), exp_data);
    check(req, "bit9 (R5)", int'(b9), (vc.nbits == 4'd9) ? int'(vc.data[8]) : 0);
    check(req, "parity error (R6)", int'(perr),
          (vc.bad_par && (vc.pmode == 2'b01 || vc.pmode == 2'b10)) ? 1 : 0);
    check(req, "frame error (R7)", int'(ferr), int'(vc.bad_stop));
    @(negedge clk);
    check(req, "strobe one cycle (R8)", int'(fv), 0);
    if (full_stop) for (int s = span / 2 + 3; s <= span; s++) put_sample(1'b1);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "strobe", int'(fv), 0);
    check("R1", "data", int'(dout), 0);
    check("R1", "bit9", int'(b9), 0);
    check("R1", "perr", int'(perr), 0);
    check("R1", "ferr", int'(ferr), 0);

    // R2 R4 R5 R6 R7 R11 vector walk
    for (int v = 0; v < NVEC; v++) run_frame(VECS[v], 2, 1'b1, "R2/R4/R5/R6/R7/R11");

    // R3 spike in normal mode: samples 8,9 high -> rejected
    c0 = strobes;
    dbl = 1'b0;
    put_sample(1'b1); put_sample(1'b1);
    for (int s = 1; s <= 7; s++) put_sample(1'b0);
    put_sample(1'b1); put_sample(1'b1); put_sample(1'b0);
    for (int s = 0; s < 30; s++) put_sample(1'b1);
    check("R3", "no strobe after normal spike", strobes, c0);
    run_frame(VECS[0], 2, 1'b1, "R3");

    // R3 spike in double mode: samples 5,6 high
    c0 = strobes;
    dbl = 1'b1;
    put_sample(1'b1);
    for (int s = 1; s <= 4; s++) put_sample(1'b0);
    put_sample(1'b1); put_sample(1'b1);
    for (int s = 0; s < 20; s++) put_sample(1'b1);
    check("R3", "no strobe after double spike", strobes, c0);
    run_frame(VECS[3], 2, 1'b1, "R3");

    // R9 next start edge straight after last stop voting sample
    run_frame(VECS[1], 2, 1'b0, "R9");
    run_frame(VECS[2], 0, 1'b0, "R9");
    run_frame(VECS[4], 0, 1'b1, "R9");

    // R10 disable mid-frame, then re-enable on a low line
    c0 = strobes;
    dbl = 1'b0;
    nbits = 4'd8;
    pmode = 2'b00;
    put_sample(1'b1); put_sample(1'b1);
    send_bit(1'b0, 16, 1'b0);
    send_bit(1'b0, 16, 1'b0);
    send_bit(1'b1, 16, 1'b0);
    @(negedge clk) en = 1'b0;
    for (int s = 0; s < 20; s++) put_sample(1'b0);
    @(negedge clk) en = 1'b1;
    for (int s = 0; s < 40; s++) put_sample(1'b0);
    for (int s = 0; s < 20; s++) put_sample(1'b1);
    check("R10", "no strobe for aborted frame", strobes, c0);
    run_frame(VECS[5], 2, 1'b1, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule